// File: doc/BRIEF.md
# NAND Hamming ECC accumulator

This block sits between a byte-wide register bus and the data pins of a NAND flash device. Every byte that software moves through the flash data window is passed on to the flash and also folded into a running single-error-correcting Hamming code. The code covers one 256-byte chunk and is kept in three raw parity registers. Software starts a chunk by writing anything to the clear address. It then streams the chunk through the data window, reads the three parity registers back, and complements them to form the three stored code bytes.

The byte position inside the chunk comes from an 8-bit counter that advances on every data-window access and wraps to zero. After a complete chunk the counter therefore reads back as zero, so software can confirm that exactly a whole chunk was processed. Reads and writes of the data window both update the code. This lets the same accumulation produce the code on the programming path and the check value on the read-back path.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, the line-parity low (0x00), line-parity high (0x04), column-parity (0x08) and byte-counter (0x0C) registers all read 0.
- R2: A bus write of any value to offset 0x10 sets all line parity, column parity and the byte counter to 0.
- R3: The byte counter at 0x0C is 8 bits wide and rises by one on every access to the data window at offset 0x14. After N accesses it reads N mod 256, so a full 256-byte chunk reads 0.
- R4: Line parity is 16 bits, with bits 7..0 at 0x00 and bits 15..8 at 0x04. For each counter bit k, bit 2k is the XOR of the parity of every byte whose position has bit k equal to 0, and bit 2k+1 covers the bytes whose position has bit k equal to 1.
- R5: Column parity sits in bits 5..0 of 0x08, and bits 7..6 read 0. For each data-bit-index bit j, bit 2j is the XOR over all bytes of the data bits whose index has bit j equal to 0, and bit 2j+1 covers the data bits whose index has bit j equal to 1.
- R6: A data-window write accumulates the written byte. A data-window read accumulates the byte on flash_rdata_i in that access cycle.
- R7: A register read returns its data on reg_rdata_o one cycle after the request. A data-window read returns the flash byte that was sampled during the request.
- R8: Writes to offsets 0x00, 0x04, 0x08 and 0x0C change no state. Reads of 0x10 and of unmapped offsets return 0.
- R9: A data-window write raises flash_wr_o and puts reg_wdata_i on flash_wdata_o in that cycle. A data-window read raises flash_rd_o. Neither strobe is raised by any other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Bus access request, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 5 | Byte offset of the register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid one cycle after the request |
| flash_wr_o | output | 1 | Flash write strobe |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_wdata_o | output | 8 | Byte driven to the flash |
| flash_rdata_i | input | 8 | Byte returned by the flash |

## Verification
The bench builds the block with its default counter width of 8, which gives a 256-byte chunk and a 16-bit line parity. With this setting the bench can run full chunks and see the counter wrap back to zero. It also exercises every line-parity pair at all 256 byte positions, and compares partial chunks against a reference parity function. Chunks written in, read in and mixed in direction, together with the all-ones pattern, reach every column-parity pair and both data directions.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_LINE_LO = 5'h00;
  localparam logic [REG_AW-1:0] OFS_LINE_HI = 5'h04;
  localparam logic [REG_AW-1:0] OFS_COL     = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CNT     = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CLR     = 5'h10;
  localparam logic [REG_AW-1:0] OFS_DATA    = 5'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LINE_LO, SEL_LINE_HI, SEL_COL, SEL_CNT, SEL_DATA
  } rd_sel_e;
endpackage

// File: rtl/nand_ecc_decode.sv
module nand_ecc_decode
  import nand_ecc_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  output logic              acc_o,
  output logic              clr_o,
  output logic              flash_wr_o,
  output logic              flash_rd_o,
  output logic              rd_o,
  output rd_sel_e           sel_o
);
  logic hit_data;

  always_comb begin
    hit_data   = req_i && (addr_i == OFS_DATA);
    acc_o      = hit_data;
    clr_o      = req_i && we_i && (addr_i == OFS_CLR);
    flash_wr_o = hit_data && we_i;
    flash_rd_o = hit_data && !we_i;
    rd_o       = req_i && !we_i;
    unique case (addr_i)
      OFS_LINE_LO: sel_o = SEL_LINE_LO;
      OFS_LINE_HI: sel_o = SEL_LINE_HI;
      OFS_COL:     sel_o = SEL_COL;
      OFS_CNT:     sel_o = SEL_CNT;
      OFS_DATA:    sel_o = SEL_DATA;
      default:     sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/nand_ecc_parity.sv
module nand_ecc_parity #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         acc_i,
  input  logic [DATA_W-1:0]            byte_i,
  output logic [2*CNT_W-1:0]           line_o,
  output logic [2*$clog2(DATA_W)-1:0]  col_o,
  output logic [CNT_W-1:0]             cnt_o
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int COL_W  = 2 * IDX_W;
  localparam int LINE_W = 2 * CNT_W;

  logic [LINE_W-1:0] line_q, line_x;
  logic [COL_W-1:0]  col_q, col_x;
  logic [CNT_W-1:0]  cnt_q;
  logic              byte_par;

  assign byte_par = ^byte_i;

  // byte parity steered into the even or odd member of each address-bit pair
  for (genvar k = 0; k < CNT_W; k++) begin : g_line
    assign line_x[2*k]   = byte_par & ~cnt_q[k];
    assign line_x[2*k+1] = byte_par &  cnt_q[k];
  end

  for (genvar j = 0; j < IDX_W; j++) begin : g_col
    logic even_p, odd_p;
    always_comb begin
      even_p = 1'b0;
      odd_p  = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (((i >> j) & 1) != 0) odd_p  = odd_p  ^ byte_i[i];
        else                     even_p = even_p ^ byte_i[i];
      end
    end
    assign col_x[2*j]   = even_p;
    assign col_x[2*j+1] = odd_p;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      col_q  <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      line_q <= '0;
      col_q  <= '0;
      cnt_q  <= '0;
    end else if (acc_i) begin
      line_q <= line_q ^ line_x;
      col_q  <= col_q ^ col_x;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign line_o = line_q;
  assign col_o  = col_q;
  assign cnt_o  = cnt_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && line_q == '0 && col_q == '0)) else $error("clear"); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)) else $error("count"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !clr_i) |=> ($stable(line_q) && $stable(col_q) && $stable(cnt_q))) else $error("hold"); // R8
  AST_LINE_PAIR_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^line_q[1:0]) == (^line_q[LINE_W-1 -: 2])) else $error("line pairs"); // R4
  AST_COL_PAIR_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^col_q[1:0]) == (^line_q[1:0])) else $error("col pairs"); // R5
endmodule

// File: rtl/nand_ecc_rdmux.sv
module nand_ecc_rdmux
  import nand_ecc_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int COL_W  = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  rd_sel_e           sel_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [7:0]        flash_rdata_i,
  output logic [7:0]        rdata_o
);
  logic [15:0] line16;
  logic [7:0]  rd_d, rdata_q;

  assign line16 = 16'(line_i);

  always_comb begin
    unique case (sel_i)
      SEL_LINE_LO: rd_d = line16[7:0];
      SEL_LINE_HI: rd_d = line16[15:8];
      SEL_COL:     rd_d = 8'(col_i);
      SEL_CNT:     rd_d = 8'(cnt_i);
      SEL_DATA:    rd_d = flash_rdata_i;
      default:     rd_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;

  AST_COL_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == SEL_COL) |=> (rdata_o >> COL_W) == 8'h00) else $error("col top"); // R5
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == SEL_DATA) |=> rdata_o == $past(flash_rdata_i)) else $error("latency"); // R7
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              flash_wr_o,
  output logic              flash_rd_o,
  output logic [7:0]        flash_wdata_o,
  input  logic [7:0]        flash_rdata_i
);
  localparam int DATA_W = 8;
  localparam int LINE_W = 2 * CNT_W;
  localparam int COL_W  = 2 * $clog2(DATA_W);

  logic              acc, clr, rd;
  rd_sel_e           sel;
  logic [DATA_W-1:0] acc_byte;
  logic [LINE_W-1:0] line;
  logic [COL_W-1:0]  col;
  logic [CNT_W-1:0]  cnt;

  nand_ecc_decode u_decode (
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .acc_o      (acc),
    .clr_o      (clr),
    .flash_wr_o (flash_wr_o),
    .flash_rd_o (flash_rd_o),
    .rd_o       (rd),
    .sel_o      (sel)
  );

  assign flash_wdata_o = reg_wdata_i;
  assign acc_byte      = reg_we_i ? reg_wdata_i : flash_rdata_i;

  nand_ecc_parity #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_parity (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .acc_i  (acc),
    .byte_i (acc_byte),
    .line_o (line),
    .col_o  (col),
    .cnt_o  (cnt)
  );

  nand_ecc_rdmux #(.LINE_W(LINE_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_rdmux (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_i          (rd),
    .sel_i         (sel),
    .line_i        (line),
    .col_i         (col),
    .cnt_i         (cnt),
    .flash_rdata_i (flash_rdata_i),
    .rdata_o       (reg_rdata_o)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_wr_o && flash_rd_o)) else $error("strobes"); // R9
endmodule

// File: tb/nand_ecc_acc_bench.sv
`timescale 1ns/1ps
module nand_ecc_acc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata, fwdata, frdata = '0;
  logic       fwr, frd;
  int         errors = 0, checks = 0;
  bit         done = 0;
  logic [7:0] chunk [256];
  bit         dir   [256];

  always #2.5 clk = ~clk;

  nand_ecc_acc u_nand_ecc_acc (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .flash_wr_o(fwr), .flash_rd_o(frd), .flash_wdata_o(fwdata),
    .flash_rdata_i(frdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_line(input int n);
    logic [15:0] l = '0;
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++)
        if (((b >> k) & 1) != 0) l[2*k+1] ^= ^chunk[b];
        else                     l[2*k]   ^= ^chunk[b];
    return l;
  endfunction

  function automatic logic [7:0] ref_col(input int n);
    logic [7:0] c = '0;
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 3; j++)
          if (((i >> j) & 1) != 0) c[2*j+1] ^= chunk[b][i];
          else                     c[2*j]   ^= chunk[b][i];
    return c;
  endfunction

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    #1;
    if (a == 5'h14) begin
      chk("R9 wr strobe", {15'd0, fwr}, 16'd1);
      chk("R9 wr data", {8'd0, fwdata}, {8'd0, d});
    end else chk("R9 no strobe", {14'd0, fwr, frd}, 16'd0);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic [7:0] fl, output logic [7:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; frdata = fl;
    #1;
    if (a == 5'h14) chk("R9 rd strobe", {15'd0, frd}, 16'd1);
    @(negedge clk);
    d = rdata; req = 0;
  endtask

  task automatic run_chunk(input int n);
    logic [7:0] d;
    for (int b = 0; b < n; b++) begin
      if (dir[b]) bus_wr(5'h14, chunk[b]);
      else begin
        bus_rd(5'h14, chunk[b], d);
        chk("R7 data read", {8'd0, d}, {8'd0, chunk[b]});
      end
    end
  endtask

  task automatic check_regs(input string tag, input int n);
    logic [7:0] lo, hi, c, cn;
    logic [15:0] l;
    l = ref_line(n);
    bus_rd(5'h00, 8'h00, lo);
    bus_rd(5'h04, 8'h00, hi);
    bus_rd(5'h08, 8'h00, c);
    bus_rd(5'h0C, 8'h00, cn);
    chk({tag, " R4 line"}, {hi, lo}, l);
    chk({tag, " R5 col"}, {8'd0, c}, {8'd0, ref_col(n)});
    chk({tag, " R3 cnt"}, {8'd0, cn}, 16'(n % 256));
  endtask

  task automatic fill(input int mode);
    for (int b = 0; b < 256; b++) begin
      chunk[b] = (mode == 0) ? 8'($urandom) : (mode == 1 ? 8'hFF : 8'h00);
      dir[b]   = 1'b1;
    end
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    fill(2);
    check_regs("R1 reset", 0);
    // random full chunk, write direction, wrap
    fill(0);
    run_chunk(256);
    check_regs("R6 write chunk", 256);
    // R2 clear with arbitrary value
    bus_wr(5'h10, 8'h5A);
    fill(2);
    check_regs("R2 clear", 0);
    // read direction, partial chunk
    fill(0);
    for (int b = 0; b < 256; b++) dir[b] = 1'b0;
    run_chunk(100);
    check_regs("R6 read partial", 100);
    // R8 writes to parity/counter ignored, unmapped reads zero
    bus_wr(5'h00, 8'hA5);
    bus_wr(5'h04, 8'h3C);
    bus_wr(5'h08, 8'hFF);
    bus_wr(5'h0C, 8'h77);
    check_regs("R8 ignored", 100);
    bus_rd(5'h10, 8'hEE, d);
    chk("R8 clr reads 0", {8'd0, d}, 16'd0);
    bus_rd(5'h18, 8'hEE, d);
    chk("R8 unmapped reads 0", {8'd0, d}, 16'd0);
    // mixed directions, full chunk
    bus_wr(5'h10, 8'h00);
    fill(0);
    for (int b = 0; b < 256; b++) dir[b] = 1'($urandom);
    run_chunk(256);
    check_regs("R6 mixed", 256);
    // all-ones corner: column top bits stay 0, counter wrap
    bus_wr(5'h10, 8'hFF);
    fill(1);
    run_chunk(255);
    check_regs("R3 cnt 255", 255);
    run_chunk(1);
    bus_rd(5'h08, 8'h00, d);
    chk("R5 col top zero", {14'd0, d[7:6]}, 16'd0);
    bus_rd(5'h0C, 8'h00, d);
    chk("R3 wrap", {8'd0, d}, 16'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule